// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt-acknowledge cycles. It follows the active-low acknowledge strobe, counts the pulses of one acknowledge sequence and, for each pulse that needs an answer, drives one byte onto an 8-bit data bus with an output enable. It does not resolve priorities. A priority core beside it presents the winning request level, and the sequencer returns two strobes. The commit strobe tells the core to set the in-service bit and clear the request bit of the returned level. The done strobe marks the end of the sequence, and when automatic end-of-interrupt is enabled it comes with a clear strobe for that in-service bit.

The block has two modes, chosen by `call_mode` when a sequence starts. In call mode, a sequence has three pulses. The first pulse commits the level and returns the opcode 0xCD. The second and third pulses return the low and high bytes of the handler address, which is the programmed 16-bit base plus the level shifted left by `STRIDE_SH`. In pointer mode, a sequence has two pulses. The first pulse is not answered. The second pulse commits the level and returns an 8-bit vector made of the 5 programmed upper bits followed by the 3-bit level.

All pins are plain levels that are sampled on the rising clock edge. The sequencer has no data stream with back-pressure: the bus byte is valid for as long as `bus_oe` is high, and the processor paces the sequence through the acknowledge strobe alone.

Top module: `ack_vector_seq`

## Requirements
- R1: After reset, and with `ack_n` high, `bus_oe`, `commit`, `seq_done` and `aeoi_clear` are all 0.
- R2: In call mode (`call_mode`=1 at the first pulse), one cycle after `ack_n` is first sampled low on the first pulse, `bus_data` is 0xCD with `bus_oe`=1. `commit` is high for exactly one cycle at that point, and `commit_level` holds the committed level.
- R3: In call mode, the second pulse drives bits [7:0] of `handler_base + (level << STRIDE_SH)` (STRIDE_SH=2 by default), and the third pulse drives bits [15:8] of the same sum.
- R4: In pointer mode (`call_mode`=0 at the first pulse), `bus_oe` stays 0 for the whole of the first pulse, and no commit occurs on that pulse.
- R5: In pointer mode, the second pulse raises `commit` for one cycle and drives `{vec_base[4:0], level[2:0]}` with `bus_oe`=1.
- R6: One cycle after the rising edge of the final pulse (the third pulse in call mode, the second in pointer mode), `seq_done` is high for one cycle. `aeoi_clear` is high in that same cycle exactly when `aeoi_en`=1, and `commit_level` still names the committed level.
- R7: `bus_oe` is 1 only while `ack_n` is low during a pulse that is answered. It is 0 in the first cycle in which `ack_n` is sampled low, and whenever `ack_n` is high.
- R8: After a sequence completes, the pulse count restarts, so the next falling edge of `ack_n` is treated as the first pulse of a new sequence.
- R9: The level is captured on the committing edge. If `req_valid` is 0 on that edge, the level is 7 (the lowest-priority level), and this is a spurious response.
- R10: The mode is fixed at the first pulse. A change of `call_mode` later in the sequence has no effect on the bytes returned or on the length of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_n | input | 1 | Interrupt-acknowledge strobe from the processor, active low |
| call_mode | input | 1 | 1 = three-byte call mode, 0 = pointer mode; sampled at the first pulse |
| aeoi_en | input | 1 | Automatic end-of-interrupt enable, sampled at the end of the sequence |
| req_valid | input | 1 | The priority core has a pending request |
| req_level | input | 3 | Winning request level from the priority core |
| handler_base | input | 16 | Programmed handler base address (call mode) |
| vec_base | input | 5 | Programmed upper vector bits (pointer mode) |
| bus_data | output | 8 | Byte returned on the data bus |
| bus_oe | output | 1 | Data bus output enable |
| commit | output | 1 | One-cycle strobe: set the in-service bit and clear the request bit of `commit_level` |
| commit_level | output | 3 | Level committed in the current sequence |
| seq_done | output | 1 | One-cycle strobe at the end of a sequence |
| aeoi_clear | output | 1 | One-cycle strobe to clear the in-service bit of `commit_level` |

## Verification
Two events can fall on the same clock edge. A request can change on the very edge that commits the level, and the end of one sequence can sit directly against the start of the next. The bench changes `req_valid` and `req_level` on the committing pulse, including between the two pulses in pointer mode, and checks that `commit_level` reports the value present on the committing edge, or 7 when no request is pending. It also starts new sequences with only a short high gap after `seq_done`, and checks that the first pulse of the new sequence is answered as a first pulse (opcode or silence) and never as a continuation of the previous count.

// File: rtl/avs_pkg.sv
package avs_pkg;
  typedef enum logic {
    MODE_PTR  = 1'b0,
    MODE_CALL = 1'b1
  } ack_mode_e;

  localparam int DATA_W  = 8;
  localparam int LEVEL_W = 3;
  localparam int CNT_W   = 2;
  localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;
endpackage

// File: rtl/avs_pulse_track.sv
module avs_pulse_track
  import avs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n,
  input  ack_mode_e        mode_in,
  output logic [CNT_W-1:0] pulse_idx,
  output logic             in_pulse,
  output ack_mode_e        mode_cur,
  output logic             commit_hit,
  output logic             end_hit
);
  logic             ack_d;
  logic [CNT_W-1:0] cnt_q;
  logic             in_pulse_q;
  ack_mode_e        mode_q;
  logic             fall, rise;
  logic [CNT_W-1:0] last_idx, commit_idx, cnt_nxt;

  assign fall       = ack_d & ~ack_n;
  assign rise       = ~ack_d & ack_n;
  assign mode_cur   = (cnt_q == '0) ? mode_in : mode_q;
  assign last_idx   = (mode_cur == MODE_CALL) ? CNT_W'(3) : CNT_W'(2);
  assign commit_idx = (mode_cur == MODE_CALL) ? CNT_W'(1) : CNT_W'(2);
  assign cnt_nxt    = cnt_q + CNT_W'(1);
  assign commit_hit = fall && (cnt_q < last_idx) && (cnt_nxt == commit_idx);
  assign end_hit    = rise && in_pulse_q && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d      <= 1'b1;
      cnt_q      <= '0;
      in_pulse_q <= 1'b0;
      mode_q     <= MODE_PTR;
    end else begin
      ack_d <= ack_n;
      if (fall && (cnt_q < last_idx)) begin
        cnt_q      <= cnt_nxt;
        in_pulse_q <= 1'b1;
        if (cnt_q == '0) mode_q <= mode_in;
      end else if (rise) begin
        in_pulse_q <= 1'b0;
        if (end_hit) cnt_q <= '0;
      end
    end
  end

  assign pulse_idx = cnt_q;
  assign in_pulse  = in_pulse_q;
endmodule

// File: rtl/avs_level_latch.sv
module avs_level_latch
  import avs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               req_valid,
  input  logic [LEVEL_W-1:0] req_level,
  output logic [LEVEL_W-1:0] level_q
);
  localparam logic [LEVEL_W-1:0] SPURIOUS_LEVEL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       level_q <= '0;
    else if (capture) level_q <= req_valid ? req_level : SPURIOUS_LEVEL;
  end
endmodule

// File: rtl/avs_byte_mux.sv
module avs_byte_mux
  import avs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int STRIDE_SH = 2
) (
  input  ack_mode_e                   mode,
  input  logic [CNT_W-1:0]            pulse_idx,
  input  logic [LEVEL_W-1:0]          level,
  input  logic [ADDR_W-1:0]           handler_base,
  input  logic [DATA_W-LEVEL_W-1:0]   vec_base,
  output logic                        answer,
  output logic [DATA_W-1:0]           data
);
  logic [ADDR_W-1:0] handler_addr;

  assign handler_addr = handler_base
                      + ({{(ADDR_W-LEVEL_W){1'b0}}, level} << STRIDE_SH);

  always_comb begin
    answer = 1'b0;
    data   = '0;
    if (mode == MODE_CALL) begin
      unique case (pulse_idx)
        CNT_W'(1): begin answer = 1'b1; data = CALL_OPCODE; end
        CNT_W'(2): begin answer = 1'b1; data = handler_addr[DATA_W-1:0]; end
        CNT_W'(3): begin answer = 1'b1; data = handler_addr[2*DATA_W-1:DATA_W]; end
        default:   begin answer = 1'b0; data = '0; end
      endcase
    end else if (pulse_idx == CNT_W'(2)) begin
      answer = 1'b1;
      data   = {vec_base, level};
    end
  end
endmodule

// File: rtl/ack_vector_seq.sv
module ack_vector_seq
  import avs_pkg::*;
#(
  parameter int STRIDE_SH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_n,
  input  logic                      call_mode,
  input  logic                      aeoi_en,
  input  logic                      req_valid,
  input  logic [LEVEL_W-1:0]        req_level,
  input  logic [2*DATA_W-1:0]       handler_base,
  input  logic [DATA_W-LEVEL_W-1:0] vec_base,
  output logic [DATA_W-1:0]         bus_data,
  output logic                      bus_oe,
  output logic                      commit,
  output logic [LEVEL_W-1:0]        commit_level,
  output logic                      seq_done,
  output logic                      aeoi_clear
);
  localparam int ADDR_W = 2 * DATA_W;

  ack_mode_e          mode_in, mode_cur;
  logic [CNT_W-1:0]   pulse_idx;
  logic               in_pulse, commit_hit, end_hit, answer;
  logic [LEVEL_W-1:0] level_q;
  logic [DATA_W-1:0]  mux_data;

  assign mode_in = call_mode ? MODE_CALL : MODE_PTR;

  avs_pulse_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_n      (ack_n),
    .mode_in    (mode_in),
    .pulse_idx  (pulse_idx),
    .in_pulse   (in_pulse),
    .mode_cur   (mode_cur),
    .commit_hit (commit_hit),
    .end_hit    (end_hit)
  );

  avs_level_latch u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (commit_hit),
    .req_valid (req_valid),
    .req_level (req_level),
    .level_q   (level_q)
  );

  avs_byte_mux #(.ADDR_W(ADDR_W), .STRIDE_SH(STRIDE_SH)) u_mux (
    .mode         (mode_cur),
    .pulse_idx    (pulse_idx),
    .level        (level_q),
    .handler_base (handler_base),
    .vec_base     (vec_base),
    .answer       (answer),
    .data         (mux_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit     <= 1'b0;
      seq_done   <= 1'b0;
      aeoi_clear <= 1'b0;
    end else begin
      commit     <= commit_hit;
      seq_done   <= end_hit;
      aeoi_clear <= end_hit & aeoi_en;
    end
  end

  assign bus_oe       = ~ack_n & in_pulse & answer;
  assign bus_data     = bus_oe ? mux_data : '0;
  assign commit_level = level_q;
endmodule

// File: rtl/ack_vector_seq_chk.sv
module ack_vector_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_n,
  input logic bus_oe,
  input logic commit,
  input logic seq_done,
  input logic aeoi_clear
);
  AST_OE_ONLY_WHILE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !ack_n); // R7
  AST_OE_QUIET_FIRST_LOW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> !bus_oe); // R7
  AST_COMMIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R2
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R6
  AST_DONE_AFTER_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(ack_n)); // R6
  AST_AECLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_clear |-> seq_done); // R6
  AST_COMMIT_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && seq_done)); // R8
endmodule

bind ack_vector_seq ack_vector_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_n      (ack_n),
  .bus_oe     (bus_oe),
  .commit     (commit),
  .seq_done   (seq_done),
  .aeoi_clear (aeoi_clear)
);

// File: tb/ack_vector_seq_tb.sv
module ack_vector_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_n = 1'b1;
  logic        call_mode = 1'b0;
  logic        aeoi_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic [15:0] handler_base = '0;
  logic [4:0]  vec_base = '0;
  logic [7:0]  bus_data;
  logic        bus_oe, commit, seq_done, aeoi_clear;
  logic [2:0]  commit_level;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ack_vector_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .call_mode(call_mode),
    .aeoi_en(aeoi_en), .req_valid(req_valid), .req_level(req_level),
    .handler_base(handler_base), .vec_base(vec_base), .bus_data(bus_data),
    .bus_oe(bus_oe), .commit(commit), .commit_level(commit_level),
    .seq_done(seq_done), .aeoi_clear(aeoi_clear)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit callm, input int idx,
      input logic [2:0] lvl, input logic [15:0] base, input logic [4:0] vb);
    logic [15:0] a;
    a = base + ({13'd0, lvl} << 2);
    if (callm) begin
      if (idx == 1) return 8'hCD;
      if (idx == 2) return a[7:0];
      return a[15:8];
    end
    return {vb, lvl};
  endfunction

  // One acknowledge pulse; samples during low and after the rising edge.
  task automatic pulse(output logic oe, output logic [7:0] d, output logic cm,
      output logic [2:0] cl, output logic oe_hi, output logic dn, output logic ac);
    @(negedge clk) ack_n = 1'b0;
    @(negedge clk);
    oe = bus_oe; d = bus_data; cm = commit; cl = commit_level;
    @(negedge clk);
    @(negedge clk) ack_n = 1'b1;
    #1 oe_hi = bus_oe;
    @(negedge clk);
    dn = seq_done; ac = aeoi_clear;
  endtask

  // Full sequence; flip_mode inverts call_mode after the first pulse,
  // lvl2 is presented on the second pulse.
  task automatic run_seq(input bit callm, input bit aeoi, input bit rv,
      input logic [2:0] lvl, input bit rv2, input logic [2:0] lvl2, input bit flip_mode);
    logic oe, cm, oe_hi, dn, ac;
    logic [7:0] d;
    logic [2:0] cl, elvl;
    int n;
    n = callm ? 3 : 2;
    call_mode = callm; aeoi_en = aeoi; req_valid = rv; req_level = lvl;
    elvl = callm ? (rv ? lvl : 3'd7) : (rv2 ? lvl2 : 3'd7);
    for (int p = 1; p <= n; p++) begin
      if (p == 2) begin
        req_valid = rv2; req_level = lvl2;
        if (flip_mode) call_mode = ~callm;
      end
      pulse(oe, d, cm, cl, oe_hi, dn, ac);
      if (!callm && p == 1) begin
        chk("R4 pointer first pulse oe", {31'd0, oe}, 32'd0);
        chk("R4 pointer first pulse commit", {31'd0, cm}, 32'd0);
      end else begin
        chk("R7 answered pulse oe", {31'd0, oe}, 32'd1);
        chk(callm ? (p == 1 ? "R2 opcode" : "R3 address byte") : "R5 vector",
            {24'd0, d}, {24'd0, exp_byte(callm, p, elvl, handler_base, vec_base)});
        if (flip_mode) chk("R10 mode held", {24'd0, d},
            {24'd0, exp_byte(callm, p, elvl, handler_base, vec_base)});
      end
      if ((callm && p == 1) || (!callm && p == 2)) begin
        chk(callm ? "R2 commit" : "R5 commit", {31'd0, cm}, 32'd1);
        chk(rv || rv2 ? "R9 level" : "R9 spurious level", {29'd0, cl}, {29'd0, elvl});
      end else if (p != 1) begin
        chk("R2 commit once", {31'd0, cm}, 32'd0);
      end
      chk("R7 oe low while ack high", {31'd0, oe_hi}, 32'd0);
      chk("R6 done", {31'd0, dn}, {31'd0, (p == n)});
      chk("R6 aeoi clear", {31'd0, ac}, {31'd0, (p == n) && aeoi});
      if (p == n) chk("R6 level held at done", {29'd0, commit_level}, {29'd0, elvl});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    handler_base = 16'h12F8; vec_base = 5'h11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset oe", {31'd0, bus_oe}, 32'd0);
    chk("R1 reset commit", {31'd0, commit}, 32'd0);
    chk("R1 reset done", {31'd0, seq_done}, 32'd0);
    chk("R1 reset aeoi", {31'd0, aeoi_clear}, 32'd0);

    // Directed corner cases
    run_seq(1'b1, 1'b0, 1'b1, 3'd7, 1'b1, 3'd7, 1'b0); // R3 carry into high byte
    run_seq(1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 3'd5, 1'b0); // R9 level taken on pulse 2
    run_seq(1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 3'd3, 1'b0); // R9 spurious, call mode
    run_seq(1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 3'd1, 1'b0); // R9 spurious, pointer mode
    run_seq(1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 3'd0, 1'b1); // R10 mode flipped to pointer
    run_seq(1'b0, 1'b0, 1'b1, 3'd6, 1'b1, 3'd6, 1'b1); // R10 mode flipped to call
    run_seq(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b0); // R8 restart after sequence

    // Constrained random sequences
    for (int i = 0; i < 60; i++) begin
      bit callm, aeoi, rv, rv2;
      logic [2:0] l1, l2;
      callm = 1'($urandom); aeoi = 1'($urandom);
      rv = ($urandom % 5) != 0; rv2 = ($urandom % 5) != 0;
      l1 = 3'($urandom); l2 = 3'($urandom);
      handler_base = 16'($urandom); vec_base = 5'($urandom);
      run_seq(callm, aeoi, rv, l1, rv2, l2, ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule